// File: doc/BRIEF.md
# Dual Reloadable Down-Counter Timer

Two independent down-counters sit behind a small register bus. Each counter owns a count register and a reload register, and a control word sets four things for each counter: whether it runs, whether it restarts from its reload value after it expires, whether it counts bus-clock cycles or pulses on a fixed-reference tick input, and a 2^N prescaler.

When a counter steps past zero it records a sticky event in a status word and drives its event output for as long as the counter stays enabled. In auto-reload mode a period of P count steps is programmed as P-1. With reload off the counter runs once, parks at zero and raises one event. Software acknowledges an event by writing zero to its status bit.

The bus is a single-cycle strobe. A write is captured on the rising clock edge and a read returns data combinationally in the same cycle.

Top module: `dual_down_timer`

## Requirements
- R1: After reset every register reads 0 and both bits of `evt_o` are 0.
- R2: Byte addresses: control 0x00, status 0x04, reload0 0x10, count0 0x14, reload1 0x18, count1 0x1C. Control fields: run0 bit 0, autoreload0 bit 1, run1 bit 2, autoreload1 bit 3, refsel0 bit 11, refsel1 bit 12, prescale0 bits 21:19, prescale1 bits 24:22. Control and reload registers read back as written, and bits with no function read 0.
- R3: With refsel at 0 a running counter takes a count step on every bus cycle, subject to the prescaler. With refsel at 1 it steps only on cycles where `ref_tick_i` is high.
- R4: A prescale value N makes one count step per 2^N count-clock cycles. The prescaler is held at zero while its counter is stopped, so the first step after enabling comes 2^N count-clock cycles after the enabling write.
- R5: In auto-reload mode, a count step taken while the count is 0 loads the reload value and sets the status bit on the same edge. The period is therefore reload+1 steps.
- R6: With autoreload off, a count step at 0 sets the status bit and leaves the count at 0. Later steps raise no new event until the count register is written or the counter is disabled.
- R7: Counter 0 expiry sets status bit 0 and counter 1 expiry sets status bit 8. Writing 0 to a status bit clears it, writing 1 leaves it unchanged, and all other status bits read 0.
- R8: If an expiry and a clearing write to the same status bit fall in the same cycle, the bit stays set.
- R9: `evt_o[i]` is the status bit of counter i ANDed with its run bit. A stopped counter keeps its count and its status bit.
- R10: A counter can be written at any time. The write takes effect on the next edge and overrides a count step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | Fixed-reference count-enable pulse |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle |
| evt_o | output | 2 | Per-counter event output |

## Verification
A prescaler that is not cleared while its counter is stopped shows up in the first count readback after enabling, which arrives one or more steps early. A reload or hold fault shows up one cycle after the zero-count step, either in the count readback or in a missing status bit. Faults in status-update ordering, including the case where an expiry meets a clearing write, show up in the status readback on the very next cycle. A gating fault on the event output shows up on the first cycle after the run bit falls while the status bit is still set.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
  localparam int NCH    = 2;
  localparam int DATA_W = 32;
  localparam int DIV_W  = 3;

  localparam int CTRL_OFF = 'h00;
  localparam int STAT_OFF = 'h04;
  localparam int RLD_OFF [NCH] = '{'h10, 'h18};
  localparam int VAL_OFF [NCH] = '{'h14, 'h1C};

  localparam int EN_POS   [NCH] = '{0, 2};
  localparam int REL_POS  [NCH] = '{1, 3};
  localparam int REF_POS  [NCH] = '{11, 12};
  localparam int DIV_POS  [NCH] = '{19, 22};
  localparam int STAT_POS [NCH] = '{0, 8};
endpackage

// File: rtl/dtimer_prescale.sv
module dtimer_prescale #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cnt_en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int PCNT_W = (1 << DIV_W) - 1;

  logic [PCNT_W-1:0] pcnt_q, mask;
  logic              wrap;

  assign mask   = ~({PCNT_W{1'b1}} << div_i);
  assign wrap   = (pcnt_q >= mask);
  assign tick_o = en_i & cnt_en_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pcnt_q <= '0;
    else if (!en_i)    pcnt_q <= '0;
    else if (cnt_en_i) pcnt_q <= wrap ? '0 : pcnt_q + 1'b1;
  end

  assert_pre_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pcnt_q == '0));
endmodule

// File: rtl/dtimer_channel.sv
module dtimer_channel #(
  parameter int CNT_W = 32,
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rel_i,
  input  logic             ref_sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ref_tick_i,
  input  logic             ld_reload_i,
  input  logic             ld_value_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] value_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] value_q, reload_q;
  logic             halted_q, tick, step, at_zero;

  dtimer_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .cnt_en_i (ref_sel_i ? ref_tick_i : 1'b1),
    .div_i    (div_i),
    .tick_o   (tick)
  );

  assign step     = tick & ~halted_q;
  assign at_zero  = (value_q == '0);
  assign expire_o = step & at_zero & ~ld_value_i;
  assign reload_o = reload_q;
  assign value_o  = value_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          reload_q <= '0;
    else if (ld_reload_i) reload_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         value_q <= '0;
    else if (ld_value_i) value_q <= wdata_i;
    else if (step) begin
      if (!at_zero)      value_q <= value_q - 1'b1;
      else if (rel_i)    value_q <= reload_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   halted_q <= 1'b0;
    else if (ld_value_i || !en_i)  halted_q <= 1'b0;
    else if (expire_o && !rel_i)   halted_q <= 1'b1;
  end

  assert_reload_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && rel_i) |=> (value_q == $past(reload_q)));
  assert_oneshot_park_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !rel_i) |=> (value_q == '0));
  assert_oneshot_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_q && !ld_value_i && en_i) |=> (!expire_o && $stable(value_q)));
  assert_stop_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !ld_value_i) |=> $stable(value_q));
  assert_write_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_value_i |=> (value_q == $past(wdata_i)));
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
  import dtimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [1:0]        evt_o
);
  logic             bus_wr, wr_ctrl, wr_stat;
  logic [NCH-1:0]   en_q, rel_q, ref_q, status_q, expire;
  logic [DIV_W-1:0] div_q [NCH];
  logic [CNT_W-1:0] reload [NCH];
  logic [CNT_W-1:0] value  [NCH];

  assign bus_wr  = bus_sel_i & bus_we_i;
  assign wr_ctrl = bus_wr && (bus_addr_i == ADDR_W'(CTRL_OFF));
  assign wr_stat = bus_wr && (bus_addr_i == ADDR_W'(STAT_OFF));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic ld_rld, ld_val;
    assign ld_rld = bus_wr && (bus_addr_i == ADDR_W'(RLD_OFF[g]));
    assign ld_val = bus_wr && (bus_addr_i == ADDR_W'(VAL_OFF[g]));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[g]  <= 1'b0;
        rel_q[g] <= 1'b0;
        ref_q[g] <= 1'b0;
        div_q[g] <= '0;
      end else if (wr_ctrl) begin
        en_q[g]  <= bus_wdata_i[EN_POS[g]];
        rel_q[g] <= bus_wdata_i[REL_POS[g]];
        ref_q[g] <= bus_wdata_i[REF_POS[g]];
        div_q[g] <= bus_wdata_i[DIV_POS[g] +: DIV_W];
      end
    end

    // expiry is OR-ed after the clear so it wins a same-cycle write
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_q[g] <= 1'b0;
      else status_q[g] <= (status_q[g] & ~(wr_stat & ~bus_wdata_i[STAT_POS[g]]))
                          | expire[g];
    end

    dtimer_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (en_q[g]),
      .rel_i       (rel_q[g]),
      .ref_sel_i   (ref_q[g]),
      .div_i       (div_q[g]),
      .ref_tick_i  (ref_tick_i),
      .ld_reload_i (ld_rld),
      .ld_value_i  (ld_val),
      .wdata_i     (bus_wdata_i[CNT_W-1:0]),
      .reload_o    (reload[g]),
      .value_o     (value[g]),
      .expire_o    (expire[g])
    );

    assign evt_o[g] = status_q[g] & en_q[g];

    assert_expiry_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire[g] |=> status_q[g]);
    assert_status_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_q[g] && !(wr_stat && !bus_wdata_i[STAT_POS[g]])) |=> status_q[g]);
    assert_status_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_stat && !bus_wdata_i[STAT_POS[g]] && !expire[g]) |=> !status_q[g]);
    assert_evt_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_o[g] |-> en_q[g]);
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(CTRL_OFF)) begin
      for (int i = 0; i < NCH; i++) begin
        bus_rdata_o[EN_POS[i]]              = en_q[i];
        bus_rdata_o[REL_POS[i]]             = rel_q[i];
        bus_rdata_o[REF_POS[i]]             = ref_q[i];
        bus_rdata_o[DIV_POS[i] +: DIV_W]    = div_q[i];
      end
    end else if (bus_addr_i == ADDR_W'(STAT_OFF)) begin
      for (int i = 0; i < NCH; i++) bus_rdata_o[STAT_POS[i]] = status_q[i];
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (bus_addr_i == ADDR_W'(RLD_OFF[i])) bus_rdata_o = DATA_W'(reload[i]);
        if (bus_addr_i == ADDR_W'(VAL_OFF[i])) bus_rdata_o = DATA_W'(value[i]);
      end
    end
  end
endmodule

// File: tb/dual_down_timer_tb.sv
module dual_down_timer_tb;
  logic        clk = 1'b0, rst_ni = 1'b0, ref_tick = 1'b0;
  logic        sel = 1'b0, we = 1'b0, probe = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0]  evt;

  int compared = 0, mismatched = 0;
  bit          q_evt [$];
  logic [31:0] q_exp [$];
  string       q_tag [$];

  always #10 clk = ~clk;

  dual_down_timer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ref_tick_i(ref_tick),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .evt_o(evt)
  );

  task automatic step_cycle();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    step_cycle();
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    q_evt.push_back(1'b0); q_exp.push_back(e); q_tag.push_back(tag);
    sel = 1'b1; we = 1'b0; addr = a; probe = 1'b1;
    step_cycle();
    sel = 1'b0; probe = 1'b0;
  endtask

  task automatic ev(input logic [1:0] e, input string tag);
    q_evt.push_back(1'b1); q_exp.push_back({30'b0, e}); q_tag.push_back(tag);
    probe = 1'b1;
    step_cycle();
    probe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // monitor: compare mid-cycle
  always @(negedge clk) begin
    if (probe) begin
      if (q_exp.size() == 0) begin
        mismatched++; compared++;
        $display("FAIL scoreboard empty: actual %h expected none", rdata);
      end else begin
        automatic bit          k = q_evt.pop_front();
        automatic logic [31:0] e = q_exp.pop_front();
        automatic string       t = q_tag.pop_front();
        automatic logic [31:0] a = k ? {30'b0, evt} : rdata;
        compared++;
        if (a !== e) begin
          mismatched++;
          $display("FAIL %s: actual %h expected %h", t, a, e);
        end
      end
    end
  end

  initial begin
    #3_000_000;
    mismatched++; compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    // R1 reset state
    rd(8'h00, 32'h0, "R1 ctrl");
    rd(8'h04, 32'h0, "R1 status");
    rd(8'h14, 32'h0, "R1 count0");
    rd(8'h18, 32'h0, "R1 reload1");
    ev(2'b00, "R1 evt");

    // counter 0 periodic, bus clock, N=0
    wr(8'h10, 32'd4);
    wr(8'h14, 32'd2);
    rd(8'h10, 32'd4, "R2 reload0 readback");
    wr(8'h00, 32'h3);
    rd(8'h14, 32'd2, "R3 count j0");
    rd(8'h14, 32'd1, "R3 count j1");
    rd(8'h14, 32'd0, "R5 count j2");
    rd(8'h14, 32'd4, "R5 reload on expiry");
    rd(8'h04, 32'h1, "R7 status bit0 set");
    ev(2'b01, "R9 evt0 high");
    wr(8'h04, 32'h0);
    rd(8'h04, 32'h0, "R7 clear by zero");
    rd(8'h04, 32'h1, "R5 period five");
    idle(3);
    wr(8'h04, 32'h0);
    rd(8'h04, 32'h1, "R8 expiry beats clear");
    wr(8'h00, 32'h0);
    rd(8'h14, 32'd2, "R9 count after stop");
    ev(2'b00, "R9 evt gated by run");
    rd(8'h04, 32'h1, "R9 status kept");
    rd(8'h14, 32'd2, "R9 count frozen");
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h1, "R7 write one no effect");
    wr(8'h04, 32'h0);
    rd(8'h04, 32'h0, "R7 cleared");

    // R10 count write while running
    wr(8'h00, 32'h3);
    wr(8'h14, 32'd9);
    rd(8'h14, 32'd9, "R10 write overrides step");
    rd(8'h14, 32'd8, "R10 counts from new value");
    wr(8'h00, 32'h0);

    // counter 1 one-shot, N=2
    wr(8'h1C, 32'd1);
    wr(8'h00, 32'h0080_0004);
    rd(8'h00, 32'h0080_0004, "R2 ctrl readback");
    idle(2);
    rd(8'h1C, 32'd1, "R4 no step before 4 cycles");
    rd(8'h1C, 32'd0, "R4 first step at 4 cycles");
    idle(2);
    rd(8'h04, 32'h0, "R4 no early expiry");
    rd(8'h04, 32'h100, "R6 status bit8 set");
    ev(2'b10, "R9 evt1 high");
    wr(8'h04, 32'hFFFF_FEFF);
    idle(5);
    rd(8'h04, 32'h0, "R6 no repeat event");
    rd(8'h1C, 32'd0, "R6 parked at zero");

    // counter 0 on reference tick
    wr(8'h14, 32'd3);
    wr(8'h00, 32'h0000_0801);
    idle(2);
    rd(8'h14, 32'd3, "R3 no steps without ref tick");
    ref_tick = 1'b1;
    idle(2);
    ref_tick = 1'b0;
    rd(8'h14, 32'd1, "R3 two ref ticks");
    idle(3);
    rd(8'h14, 32'd1, "R3 holds without ref tick");

    idle(2);
    if (q_exp.size() != 0) begin
      mismatched++; compared++;
      $display("FAIL scoreboard residue: actual %0d expected 0", q_exp.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule